// File: doc/BRIEF.md
# Iterative Triple-DES Engine with Host-Paced Key Sequencing

This block runs triple DES on 64-bit words, one Feistel round per clock. An operation is three full DES passes of sixteen rounds each, so it takes 48 enabled clocks. The engine keeps none of the three 64-bit keys. A 2-bit key-select output tells the host which key to drive on a single shared key input. The host drives that key ahead of the pass that uses it, and the engine samples the key input only on the first round of each pass.

The host holds the run enable high and presents the first key, the data word and the direction bit together. With the direction bit at 1 the passes run encrypt, decrypt, encrypt. With it at 0 the passes run decrypt, encrypt, decrypt, and the host supplies the keys in the opposite order to undo an encryption. The result appears for exactly one cycle, marked by a valid strobe. The host must capture it in that cycle. Words can follow each other with no idle clock between them.

Top module: `tdes_core`

## Requirements
- R1: With `encrypt` at 1 and the keys driven as first, second and third, the result is DES-encrypt(third, DES-decrypt(second, DES-encrypt(first, word))). With all three keys equal, this reduces to single DES.
- R2: With `encrypt` at 0, each pass runs in the opposite direction: decrypt, encrypt, decrypt. Driving the three keys of an encryption in reverse order returns the original plaintext.
- R3: `keySel` reads 0 from the start of an operation. It reads 1 (request second key) after the 15th enabled edge, 2 (request third key) after the 31st, and 0 again after the 48th. It never reads 3.
- R4: `keyIn` is sampled only at enabled edges 1, 17 and 33 of an operation. Its value at every other edge has no effect on the result.
- R5: `dataIn` is sampled only at the first enabled edge of an operation. Later passes take their input from the previous pass, and `dataIn` has no effect after edge 1.
- R6: `dataValid` is high for exactly the one cycle after the 48th enabled edge, and `dataOut` holds the result during that cycle.
- R7: With `runEn` held high, the next operation begins at the 49th edge. That edge samples the new word and first key, with no idle cycle between operations.
- R8: Dropping `runEn` mid-operation returns the sequencer to idle: `keySel` reads 0 after the next edge, and no valid strobe is produced for the abandoned word. A later operation completes normally.
- R9: While `rstN` is low, and in the cycle after it is released, `keySel` is 0 and `dataValid` is 0, including when reset arrives during an operation.
- R10: The direction bit is sampled at the first enabled edge of an operation. Changing `encrypt` later in that operation has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run enable, held high for the whole operation |
| encrypt | input | 1 | Direction: 1 runs E-D-E, 0 runs D-E-D |
| dataIn | input | 64 | Input word, sampled at the first edge of an operation |
| keyIn | input | 64 | Shared key input, sampled at the first edge of each pass |
| keySel | output | 2 | Index of the key the host must drive next |
| dataOut | output | 64 | Result, valid while `dataValid` is high |
| dataValid | output | 1 | One-cycle result strobe |

## Verification
Known-answer vectors pin down the DES tables and the permutation bit order. A bit-order or S-box error gives a wrong word even when all three keys are equal. The key-select and strobe checks run at every edge across back-to-back words. An off-by-one in the sequencer moves the 01 or 10 step, or the strobe, by a cycle. It also makes the engine sample the key one edge too early or too late, which then breaks the result. Some words are sent with junk on the key and data inputs outside their sampling edges and with the direction bit flipped mid-operation. A design that samples those inputs at the wrong time gives a wrong word. An abort and a mid-operation reset check that a stale counter produces no late strobe and that the next word still lines up.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  localparam int BLK_W     = 64;
  localparam int HALF_W    = BLK_W / 2;
  localparam int KEY_W     = 64;
  localparam int CD_W      = 56;
  localparam int CD_HALF_W = CD_W / 2;
  localparam int SUB_W     = 48;
  localparam int ROUNDS    = 16;
  localparam int PASSES    = 3;
  localparam int OP_CYCLES = ROUNDS * PASSES;
  localparam int CNT_W     = $clog2(OP_CYCLES);
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int SEL_W     = 2;
  localparam int NUM_SBOX  = 8;

  // Control strobes from sequencer to datapath.
  typedef struct packed {
    logic             step;         // an enabled edge: advance one round
    logic             firstOfOp;    // round 0 of pass 0: take dataIn
    logic             firstOfPass;  // round 0 of any pass: take keyIn
    logic             fwd;          // pass runs in the encrypt direction
    logic [RND_W-1:0] round;        // round index within the pass
  } tdesCtl_t;

  // Rounds whose key rotation is by two positions (others rotate by one).
  localparam logic [0:ROUNDS-1] DOUBLE_SHIFT = 16'b0011_1111_0111_1110;

  localparam logic [0:31][7:0] P_TAB = {
    8'd16, 8'd7,  8'd20, 8'd21, 8'd29, 8'd12, 8'd28, 8'd17,
    8'd1,  8'd15, 8'd23, 8'd26, 8'd5,  8'd18, 8'd31, 8'd10,
    8'd2,  8'd8,  8'd24, 8'd14, 8'd32, 8'd27, 8'd3,  8'd9,
    8'd19, 8'd13, 8'd30, 8'd6,  8'd22, 8'd11, 8'd4,  8'd25};

  localparam logic [0:55][7:0] PC1_TAB = {
    8'd57, 8'd49, 8'd41, 8'd33, 8'd25, 8'd17, 8'd9,
    8'd1,  8'd58, 8'd50, 8'd42, 8'd34, 8'd26, 8'd18,
    8'd10, 8'd2,  8'd59, 8'd51, 8'd43, 8'd35, 8'd27,
    8'd19, 8'd11, 8'd3,  8'd60, 8'd52, 8'd44, 8'd36,
    8'd63, 8'd55, 8'd47, 8'd39, 8'd31, 8'd23, 8'd15,
    8'd7,  8'd62, 8'd54, 8'd46, 8'd38, 8'd30, 8'd22,
    8'd14, 8'd6,  8'd61, 8'd53, 8'd45, 8'd37, 8'd29,
    8'd21, 8'd13, 8'd5,  8'd28, 8'd20, 8'd12, 8'd4};

  localparam logic [0:47][7:0] PC2_TAB = {
    8'd14, 8'd17, 8'd11, 8'd24, 8'd1,  8'd5,
    8'd3,  8'd28, 8'd15, 8'd6,  8'd21, 8'd10,
    8'd23, 8'd19, 8'd12, 8'd4,  8'd26, 8'd8,
    8'd16, 8'd7,  8'd27, 8'd20, 8'd13, 8'd2,
    8'd41, 8'd52, 8'd31, 8'd37, 8'd47, 8'd55,
    8'd30, 8'd40, 8'd51, 8'd45, 8'd33, 8'd48,
    8'd44, 8'd49, 8'd39, 8'd56, 8'd34, 8'd53,
    8'd46, 8'd42, 8'd50, 8'd36, 8'd29, 8'd32};

  // Each S-box: 64 nibbles, row-major (row = outer bits, column = inner four).
  localparam logic [0:NUM_SBOX-1][255:0] SBOX = {
    256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175B3EA06D,
    256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
    256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
    256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
    256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
    256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
    256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
    256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B};

  // Source bit (1-based, MSB = bit 1) of output position i of the initial permutation.
  function automatic int ipSource(input int i);
    int row;
    int col;
    row = i / 8;
    col = i % 8;
    return (row < 4) ? (58 + 2 * row - 8 * col) : (57 + 2 * (row - 4) - 8 * col);
  endfunction

  function automatic logic [BLK_W-1:0] initPerm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-1-i] = x[BLK_W-ipSource(i)];
    return y;
  endfunction

  function automatic logic [BLK_W-1:0] finalPerm(input logic [BLK_W-1:0] x);
    logic [BLK_W-1:0] y;
    for (int i = 0; i < BLK_W; i++) y[BLK_W-ipSource(i)] = x[BLK_W-1-i];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] expandHalf(input logic [HALF_W-1:0] r);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++)
      y[SUB_W-1-i] = r[HALF_W-1-((4 * (i / 6) + (i % 6) + HALF_W - 1) % HALF_W)];
    return y;
  endfunction

  function automatic logic [HALF_W-1:0] pPerm(input logic [HALF_W-1:0] x);
    logic [HALF_W-1:0] y;
    for (int i = 0; i < HALF_W; i++) y[HALF_W-1-i] = x[HALF_W-int'(P_TAB[i])];
    return y;
  endfunction

  function automatic logic [CD_W-1:0] pc1(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] y;
    for (int i = 0; i < CD_W; i++) y[CD_W-1-i] = k[KEY_W-int'(PC1_TAB[i])];
    return y;
  endfunction

  function automatic logic [SUB_W-1:0] pc2(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] y;
    for (int i = 0; i < SUB_W; i++) y[SUB_W-1-i] = cd[CD_W-int'(PC2_TAB[i])];
    return y;
  endfunction

  function automatic logic [3:0] sboxLookup(input int box, input logic [5:0] b);
    int idx;
    idx = int'({b[5], b[0], b[4:1]});
    return SBOX[box][255-4*idx -: 4];
  endfunction

  function automatic logic [HALF_W-1:0] feistel(input logic [HALF_W-1:0] r,
                                                input logic [SUB_W-1:0] k);
    logic [SUB_W-1:0]  x;
    logic [HALF_W-1:0] s;
    x = expandHalf(r) ^ k;
    for (int i = 0; i < NUM_SBOX; i++) s[HALF_W-1-4*i -: 4] = sboxLookup(i, x[SUB_W-1-6*i -: 6]);
    return pPerm(s);
  endfunction

  // Key rotation for a round: left in the encrypt direction, right (and none
  // on round 0) in the decrypt direction.
  function automatic int shiftAmt(input logic [RND_W-1:0] rnd, input logic fwd);
    int j;
    j = int'(rnd);
    if (fwd) return DOUBLE_SHIFT[j] ? 2 : 1;
    if (j == 0) return 0;
    return DOUBLE_SHIFT[ROUNDS-j] ? 2 : 1;
  endfunction

  function automatic logic [CD_W-1:0] rotateKey(input logic [CD_W-1:0] cd, input int amt,
                                                input logic fwd);
    logic [CD_HALF_W-1:0] c;
    logic [CD_HALF_W-1:0] d;
    c = cd[CD_W-1:CD_HALF_W];
    d = cd[CD_HALF_W-1:0];
    for (int s = 0; s < 2; s++) begin
      if (s < amt) begin
        if (fwd) begin
          c = {c[CD_HALF_W-2:0], c[CD_HALF_W-1]};
          d = {d[CD_HALF_W-2:0], d[CD_HALF_W-1]};
        end else begin
          c = {c[0], c[CD_HALF_W-1:1]};
          d = {d[0], d[CD_HALF_W-1:1]};
        end
      end
    end
    return {c, d};
  endfunction

endpackage

// File: rtl/tdes_ctrl.sv
module tdes_ctrl
  import tdes_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             encrypt,
  output tdesCtl_t         ctl,
  output logic [SEL_W-1:0] keySel,
  output logic             dataValid
);

  localparam int LAST_STEP = OP_CYCLES - 1;

  logic [CNT_W-1:0] cnt;
  logic             modeQ;
  logic             lastStep;
  logic             opEnc;
  logic [SEL_W-1:0] keySelNext;
  int               passIdx;
  int               selAhead;

  assign lastStep = (cnt == CNT_W'(LAST_STEP));

  always_comb begin
    passIdx         = int'(cnt) / ROUNDS;
    opEnc           = (cnt == '0) ? encrypt : modeQ;
    ctl.step        = runEn;
    ctl.firstOfOp   = (cnt == '0);
    ctl.round       = cnt[RND_W-1:0];
    ctl.firstOfPass = (cnt[RND_W-1:0] == '0);
    ctl.fwd         = opEnc ^ ((passIdx % 2) == 1);
  end

  // Key request runs one round ahead of the pass boundary.
  always_comb begin
    selAhead = (int'(cnt) + 2) / ROUNDS;
    if (selAhead > PASSES - 1) selAhead = PASSES - 1;
    keySelNext = lastStep ? '0 : SEL_W'(selAhead);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      modeQ     <= 1'b0;
      keySel    <= '0;
      dataValid <= 1'b0;
    end else if (!runEn) begin
      cnt       <= '0;
      keySel    <= '0;
      dataValid <= 1'b0;
    end else begin
      cnt       <= lastStep ? '0 : cnt + 1'b1;
      if (cnt == '0) modeQ <= encrypt;
      keySel    <= keySelNext;
      dataValid <= lastStep;
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_keysel_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    keySel != 2'd3);

  assert_keysel_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (keySel != $past(keySel)) |-> (keySel == $past(keySel) + 2'd1 || keySel == 2'd0));

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (keySel == 2'd0 && !dataValid));

  assert_valid_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> (keySel == 2'd0 && $past(runEn)));

endmodule

// File: rtl/tdes_datapath.sv
module tdes_datapath
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tdesCtl_t          ctl,
  input  logic [BLK_W-1:0]  dataIn,
  input  logic [KEY_W-1:0]  keyIn,
  output logic [BLK_W-1:0]  dataOut
);

  logic [HALF_W-1:0] lReg;
  logic [HALF_W-1:0] rReg;
  logic [CD_W-1:0]   cdReg;

  logic [CD_W-1:0]   cdBase;
  logic [CD_W-1:0]   cdNext;
  logic [SUB_W-1:0]  subKey;
  logic [BLK_W-1:0]  passIn;
  logic [BLK_W-1:0]  blockBase;
  logic [HALF_W-1:0] lNext;
  logic [HALF_W-1:0] rNext;

  // Pass output: halves swapped after round 16, then the final permutation.
  assign dataOut = finalPerm({rReg, lReg});

  always_comb begin
    cdBase    = ctl.firstOfPass ? pc1(keyIn) : cdReg;
    cdNext    = rotateKey(cdBase, shiftAmt(ctl.round, ctl.fwd), ctl.fwd);
    subKey    = pc2(cdNext);
    passIn    = ctl.firstOfOp ? dataIn : dataOut;
    blockBase = ctl.firstOfPass ? initPerm(passIn) : {lReg, rReg};
    lNext     = blockBase[HALF_W-1:0];
    rNext     = blockBase[BLK_W-1:HALF_W] ^ feistel(blockBase[HALF_W-1:0], subKey);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lReg  <= '0;
      rReg  <= '0;
      cdReg <= '0;
    end else if (ctl.step) begin
      lReg  <= lNext;
      rReg  <= rNext;
      cdReg <= cdNext;
    end
  end

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |=> ($stable(lReg) && $stable(rReg) && $stable(cdReg)));

  assert_round_chain_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.firstOfPass) |=> (lReg == $past(rReg)));

endmodule

// File: rtl/tdes_core.sv
module tdes_core
  import tdes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              encrypt,
  input  logic [BLK_W-1:0]  dataIn,
  input  logic [KEY_W-1:0]  keyIn,
  output logic [SEL_W-1:0]  keySel,
  output logic [BLK_W-1:0]  dataOut,
  output logic              dataValid
);

  tdesCtl_t ctl;

  tdes_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .encrypt   (encrypt),
    .ctl       (ctl),
    .keySel    (keySel),
    .dataValid (dataValid)
  );

  tdes_datapath u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .keyIn   (keyIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tdes_core_tb.sv
`timescale 1ns/1ps
module tdes_core_tb;
  import tdes_pkg::*;

  localparam real CLK_HALF = 2.0;
  localparam int  WATCHDOG_CYCLES = 200000;
  localparam int  NUM_VECS = 6;

  typedef struct packed {
    logic        enc;
    logic        roundTrip;   // din/exp taken from the previous vector, swapped
    logic        scramble;    // junk on keyIn/dataIn/encrypt outside sampling edges
    logic [63:0] k1;
    logic [63:0] k2;
    logic [63:0] k3;
    logic [63:0] din;
    logic        hasKat;
    logic [63:0] kat;
  } vec_t;

  localparam vec_t VECS [0:NUM_VECS-1] = '{
    '{1'b1, 1'b0, 1'b0, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1,
      64'h0123456789ABCDEF, 1'b1, 64'h85E813540F0AB405},
    '{1'b1, 1'b0, 1'b1, 64'h0E329232EA6D0D73, 64'h0E329232EA6D0D73, 64'h0E329232EA6D0D73,
      64'h8787878787878787, 1'b1, 64'h0000000000000000},
    '{1'b0, 1'b0, 1'b0, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1, 64'h133457799BBCDFF1,
      64'h85E813540F0AB405, 1'b1, 64'h0123456789ABCDEF},
    '{1'b1, 1'b0, 1'b1, 64'h0123456789ABCDEF, 64'h23456789ABCDEF01, 64'h456789ABCDEF0123,
      64'h5468652071756663, 1'b0, 64'h0},
    '{1'b0, 1'b1, 1'b0, 64'h456789ABCDEF0123, 64'h23456789ABCDEF01, 64'h0123456789ABCDEF,
      64'h0, 1'b0, 64'h0},
    '{1'b1, 1'b0, 1'b1, 64'hFEDCBA9876543210, 64'h0F1E2D3C4B5A6978, 64'h1122334455667788,
      64'hFFFFFFFFFFFFFFFF, 1'b0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        encrypt = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] keyIn = '0;
  logic [1:0]  keySel;
  logic [63:0] dataOut;
  logic        dataValid;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  tdes_core u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .encrypt   (encrypt),
    .dataIn    (dataIn),
    .keyIn     (keyIn),
    .keySel    (keySel),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

  // Reference: subkeys precomputed per DES, then sixteen rounds.
  function automatic logic [63:0] refDes(input logic [63:0] blk, input logic [63:0] key,
                                         input bit enc);
    logic [47:0] ks [16];
    logic [55:0] cd;
    logic [27:0] c;
    logic [27:0] d;
    logic [63:0] b;
    logic [31:0] l;
    logic [31:0] r;
    logic [31:0] t;
    cd = pc1(key);
    c  = cd[55:28];
    d  = cd[27:0];
    for (int i = 0; i < 16; i++) begin
      int n;
      n = (i == 0 || i == 1 || i == 8 || i == 15) ? 1 : 2;
      c = (c << n) | (c >> (28 - n));
      d = (d << n) | (d >> (28 - n));
      ks[i] = pc2({c, d});
    end
    b = initPerm(blk);
    l = b[63:32];
    r = b[31:0];
    for (int i = 0; i < 16; i++) begin
      t = r;
      r = l ^ feistel(r, enc ? ks[i] : ks[15-i]);
      l = t;
    end
    return finalPerm({r, l});
  endfunction

  function automatic logic [63:0] refTdes(input bit enc, input logic [63:0] k1,
                                          input logic [63:0] k2, input logic [63:0] k3,
                                          input logic [63:0] x);
    return refDes(refDes(refDes(x, k1, enc), k2, !enc), k3, enc);
  endfunction

  function automatic logic [1:0] expSel(input int e);
    if (e >= 48) return 2'd0;
    if (e >= 31) return 2'd2;
    if (e >= 15) return 2'd1;
    return 2'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called just after a falling edge; returns just after the falling edge that
  // follows the 48th rising edge, so a following call is back to back (R7).
  task automatic doOp(input bit enc, input logic [63:0] k1, input logic [63:0] k2,
                      input logic [63:0] k3, input logic [63:0] din,
                      input logic [63:0] exp, input bit scramble);
    runEn   = 1'b1;
    encrypt = enc;
    dataIn  = din;
    keyIn   = k1;
    for (int e = 1; e <= 48; e++) begin
      @(posedge clk);
      #1;
      check(keySel == expSel(e), "R3 keySel", {62'd0, keySel}, {62'd0, expSel(e)});
      check(dataValid == (e == 48), "R6 dataValid", {63'd0, dataValid}, {63'd0, e == 48});
      if (e == 48) check(dataOut == exp, enc ? "R1 result" : "R2 result", dataOut, exp);
      @(negedge clk);
      if (e < 48) begin
        int nx;
        nx = e + 1;
        if (nx == 17)      keyIn = k2;
        else if (nx == 33) keyIn = k3;
        else if (scramble) keyIn = {32'hC0FFEE00 ^ 32'(nx), 32'h5A5A1234 + 32'(nx)};
        else               keyIn = (nx < 17) ? k1 : (nx < 33) ? k2 : k3;
        if (scramble) begin
          dataIn  = {32'h13579BDF + 32'(nx), 32'hFEED0000 ^ 32'(nx)};
          encrypt = ~enc;
        end
      end
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [63:0] prevDin;
    logic [63:0] prevExp;
    int          seenValid;
    prevDin = '0;
    prevExp = '0;

    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check(keySel == 2'd0, "R9 keySel in reset", {62'd0, keySel}, 64'd0);
    check(dataValid == 1'b0, "R9 dataValid in reset", {63'd0, dataValid}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(keySel == 2'd0 && !dataValid, "R9 after release", {61'd0, dataValid, keySel}, 64'd0);
    @(negedge clk);

    // Vector table, words back to back (R1 R2 R4 R5 R7 R10)
    for (int i = 0; i < NUM_VECS; i++) begin
      logic [63:0] din;
      logic [63:0] exp;
      if (VECS[i].roundTrip) begin
        din = prevExp;
        exp = prevDin;
      end else begin
        din = VECS[i].din;
        exp = refTdes(VECS[i].enc, VECS[i].k1, VECS[i].k2, VECS[i].k3, din);
        if (VECS[i].hasKat) begin
          check(exp == VECS[i].kat, "R1 reference model known answer", exp, VECS[i].kat);
          exp = VECS[i].kat;
        end
      end
      doOp(VECS[i].enc, VECS[i].k1, VECS[i].k2, VECS[i].k3, din, exp, VECS[i].scramble);
      prevDin = din;
      prevExp = exp;
    end

    // R8: abort after 20 edges
    runEn   = 1'b1;
    encrypt = 1'b1;
    dataIn  = VECS[0].din;
    keyIn   = VECS[0].k1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    runEn = 1'b0;
    @(posedge clk);
    #1;
    check(keySel == 2'd0 && !dataValid, "R8 abort idle", {61'd0, dataValid, keySel}, 64'd0);
    seenValid = 0;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk);
      #1;
      if (dataValid) seenValid++;
    end
    check(seenValid == 0, "R8 no strobe for abandoned word", 64'(seenValid), 64'd0);
    @(negedge clk);
    doOp(1'b1, VECS[0].k1, VECS[0].k2, VECS[0].k3, VECS[0].din, VECS[0].kat, 1'b0);

    // R9: reset in mid-operation, then a clean operation
    repeat (10) @(posedge clk);
    #1;
    rstN = 1'b0;
    #1;
    check(keySel == 2'd0 && !dataValid, "R9 reset mid-op", {61'd0, dataValid, keySel}, 64'd0);
    @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doOp(1'b1, VECS[3].k1, VECS[3].k2, VECS[3].k3, VECS[3].din,
         refTdes(1'b1, VECS[3].k1, VECS[3].k2, VECS[3].k3, VECS[3].din), 1'b1);
    runEn = 1'b0;
    @(posedge clk);
    #1;
    check(!dataValid, "R6 single-cycle strobe", {63'd0, dataValid}, 64'd0);

    finish();
  end

endmodule